// File: doc/BRIEF.md
# I/O Expansion Window Qualifier and Slave Select Decoder

This block lives on the bus-master side of a backplane whose I/O space is 16 bits wide. Some slave boards decode only the low 8 or 10 address bits. Left unqualified, such a board would answer at every address that shares those low bits. The block watches each I/O cycle and drives an active-low expansion qualifier whenever the cycle addresses a reserved window at the top of the map (by default FC00 hex and above). Partial-decode slaves are allowed to respond only while that qualifier is low, so their low-byte aliases all fall inside the reserved window. Full-decode slaves respond only while it is high.

A parameterized set of slave-select decoders is built next to the qualifier. Each decoder models one board: an 8-bit partial decoder, a 10-bit partial decoder or a full 16-bit decoder, each with its own base address. At the first clock edge of an I/O request, the block captures the qualifier and the cycle address and holds both until the request is released. A window-enable input set low turns the qualifier off entirely, which models a master with no expansion support. A conflict output flags any cycle in which two or more selects are active together.

Top module: `ioexp_window_decoder`

## Requirements
- R1: At the first clock edge where `io_req_i` is high, the block captures `qual_n_o` as 0 if `win_en_i` is 1 and `addr_i` >= `WIN_LO` (FC00 hex by default), and as 1 otherwise. The captured value is visible after that edge.
- R2: A slave of kind 0 (8-bit partial) matches when captured address bits [7:0] equal its base bits [7:0]. Bits [15:8] are ignored.
- R3: A slave of kind 1 (10-bit partial) matches when captured address bits [9:0] equal its base bits [9:0]. Bits [15:10] are ignored.
- R4: A partial slave (kind 0 or 1) may select only while `qual_n_o` is 0. A slave of kind 2 (full decode) compares all 16 bits and may select only while `qual_n_o` is 1.
- R5: With the default parameters, slave 0 (8-bit, base B2) selects at exactly FCB2, FDB2, FEB2 and FFB2. No partial slave ever selects for an address below 0400.
- R6: A select is driven only while `io_req_i` is high, the cycle has been captured, and `rd_i` or `wr_i` is high. One edge after `io_req_i` goes low, `qual_n_o` is 1, and all selects are 0 while the request is low.
- R7: While `io_req_i` stays high, changes on `addr_i` or `win_en_i` after the capture edge do not affect `qual_n_o` or the decoded selects.
- R8: With `win_en_i` at 0, `qual_n_o` stays 1 and no partial slave selects. Full-decode slaves still decode normally.
- R9: `conflict_o` is 1 exactly when two or more bits of `sel_o` are 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_en_i | input | 1 | Enables the expansion window qualifier |
| io_req_i | input | 1 | I/O request strobe, high for the whole cycle |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 16 | I/O address |
| qual_n_o | output | 1 | Active-low expansion qualifier |
| sel_o | output | NUM_SLV | One select per modelled slave |
| conflict_o | output | 1 | More than one select active |

## Verification
The bench uses the default build of four slaves: an 8-bit slave at B2, a 10-bit slave at 2C4, a full-decode slave at 0060, and a 10-bit slave at 0B2. The last one deliberately overlaps the 8-bit slave at FCB2, so the conflict flag can be driven. With one cycle per address, all 65536 addresses are swept with the window enabled. For each address the bench compares the full select vector, the qualifier and the conflict flag against the exact alias sets the requirements give. Further scenarios cover mid-cycle address and enable changes, strobe gating and the disabled-window mode.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
    localparam int ADDR_W = 16;

    typedef enum logic [1:0] {
        KIND_A8   = 2'd0,
        KIND_A10  = 2'd1,
        KIND_FULL = 2'd2
    } slv_kind_e;

    typedef struct packed {
        logic              active;
        logic              qual_n;
        logic [ADDR_W-1:0] addr;
    } cyc_state_t;
endpackage

// File: rtl/iowin_qual.sv
module iowin_qual
    import iowin_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_LO = 16'hFC00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_en_i,
    input  logic              io_req_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              active_o,
    output logic              qual_n_o,
    output logic [ADDR_W-1:0] cap_addr_o
);
    cyc_state_t st_d, st_q;
    logic       in_win;

    always_comb begin
        in_win = (addr_i >= WIN_LO);
        st_d   = st_q;
        if (!io_req_i) begin
            st_d.active = 1'b0;
            st_d.qual_n = 1'b1;
        end else if (!st_q.active) begin
            // first edge of the cycle: capture window decision and address
            st_d.active = 1'b1;
            st_d.qual_n = ~(win_en_i & in_win);
            st_d.addr   = addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, qual_n: 1'b1, addr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o   = st_q.active;
    assign qual_n_o   = st_q.qual_n;
    assign cap_addr_o = st_q.addr;
endmodule

// File: rtl/iowin_slave_dec.sv
module iowin_slave_dec
    import iowin_pkg::*;
#(
    parameter logic [1:0]        KIND = 2'd0,
    parameter logic [ADDR_W-1:0] BASE = 16'h0000
) (
    input  logic              cyc_ok_i,
    input  logic              qual_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              sel_o
);
    localparam int CMP_W = (KIND == KIND_A8)  ? 8  :
                           (KIND == KIND_A10) ? 10 : ADDR_W;
    localparam logic [ADDR_W-1:0] MASK = {ADDR_W{1'b1}} >> (ADDR_W - CMP_W);

    logic hit;
    logic qual_ok;

    assign hit = (((addr_i ^ BASE) & MASK) == '0);

    generate
        if (KIND == KIND_FULL) begin : g_full
            assign qual_ok = qual_n_i;
        end else begin : g_partial
            assign qual_ok = ~qual_n_i;
        end
    endgenerate

    assign sel_o = cyc_ok_i & qual_ok & hit;
endmodule

// File: rtl/iowin_conflict.sv
module iowin_conflict #(
    parameter int NUM_SLV = 4
) (
    input  logic [NUM_SLV-1:0] sel_i,
    output logic               conflict_o
);
    localparam int CNT_W = $clog2(NUM_SLV + 1);

    logic [CNT_W-1:0] cnt;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < NUM_SLV; i++) begin
            cnt = cnt + CNT_W'(sel_i[i]);
        end
        conflict_o = (cnt > CNT_W'(1));
    end
endmodule

// File: rtl/ioexp_window_decoder.sv
module ioexp_window_decoder
    import iowin_pkg::*;
#(
    parameter int                        NUM_SLV  = 4,
    parameter logic [ADDR_W-1:0]         WIN_LO   = 16'hFC00,
    parameter logic [NUM_SLV*2-1:0]      SLV_KIND = {2'd1, 2'd2, 2'd1, 2'd0},
    parameter logic [NUM_SLV*ADDR_W-1:0] SLV_BASE = {16'h00B2, 16'h0060, 16'h02C4, 16'h00B2}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_en_i,
    input  logic               io_req_i,
    input  logic               rd_i,
    input  logic               wr_i,
    input  logic [15:0]        addr_i,
    output logic               qual_n_o,
    output logic [NUM_SLV-1:0] sel_o,
    output logic               conflict_o
);
    logic              active;
    logic [ADDR_W-1:0] cap_addr;
    logic              cyc_ok;

    iowin_qual #(.WIN_LO(WIN_LO)) qual_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_en_i  (win_en_i),
        .io_req_i  (io_req_i),
        .addr_i    (addr_i),
        .active_o  (active),
        .qual_n_o  (qual_n_o),
        .cap_addr_o(cap_addr)
    );

    assign cyc_ok = io_req_i & active & (rd_i | wr_i);

    generate
        for (genvar s = 0; s < NUM_SLV; s++) begin : g_slv
            iowin_slave_dec #(
                .KIND(SLV_KIND[s*2 +: 2]),
                .BASE(SLV_BASE[s*ADDR_W +: ADDR_W])
            ) dec_i (
                .cyc_ok_i(cyc_ok),
                .qual_n_i(qual_n_o),
                .addr_i  (cap_addr),
                .sel_o   (sel_o[s])
            );
        end
    endgenerate

    iowin_conflict #(.NUM_SLV(NUM_SLV)) conf_i (
        .sel_i     (sel_o),
        .conflict_o(conflict_o)
    );
endmodule

// File: rtl/ioexp_window_decoder_chk.sv
module ioexp_window_decoder_chk #(
    parameter int                   NUM_SLV  = 4,
    parameter logic [15:0]          WIN_LO   = 16'hFC00,
    parameter logic [NUM_SLV*2-1:0] SLV_KIND = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               win_en_i,
    input logic               io_req_i,
    input logic [15:0]        addr_i,
    input logic               qual_n_o,
    input logic [NUM_SLV-1:0] sel_o,
    input logic               conflict_o
);
    // R1 / R8: the qualifier only falls for an enabled window hit
    a_r1_fall_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(qual_n_o) |-> $past(win_en_i && io_req_i && (addr_i >= WIN_LO)));

    // R6: back to idle one edge after the request drops
    a_r6_idle_qual_high: assert property (@(posedge clk) disable iff (!rst_n)
        !io_req_i |=> qual_n_o);

    a_r6_idle_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
        !io_req_i |-> (sel_o == '0));

    // R7: qualifier held through a long request
    a_r7_qual_held: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req_i && $past(io_req_i) && $past(io_req_i, 2)) |-> $stable(qual_n_o));

    // R9: no conflict flag means at most one select
    a_r9_single_sel: assert property (@(posedge clk) disable iff (!rst_n)
        !conflict_o |-> $onehot0(sel_o));

    a_r9_flag_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_o |-> ($countones(sel_o) > 1));

    generate
        for (genvar s = 0; s < NUM_SLV; s++) begin : g_chk
            if (SLV_KIND[s*2 +: 2] == 2'd2) begin : g_full
                // R4: full decode only with qualifier high
                a_r4_full_high: assert property (@(posedge clk) disable iff (!rst_n)
                    sel_o[s] |-> qual_n_o);
            end else begin : g_part
                // R4: partial decode only with qualifier low
                a_r4_part_low: assert property (@(posedge clk) disable iff (!rst_n)
                    sel_o[s] |-> !qual_n_o);
            end
        end
    endgenerate
endmodule

bind ioexp_window_decoder ioexp_window_decoder_chk #(
    .NUM_SLV (NUM_SLV),
    .WIN_LO  (WIN_LO),
    .SLV_KIND(SLV_KIND)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_en_i  (win_en_i),
    .io_req_i  (io_req_i),
    .addr_i    (addr_i),
    .qual_n_o  (qual_n_o),
    .sel_o     (sel_o),
    .conflict_o(conflict_o)
);

// File: tb/ioexp_window_decoder_tb_top.sv
module ioexp_window_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_en_i = 1'b1;
    logic        io_req_i = 1'b0;
    logic        rd_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic        qual_n_o;
    logic [3:0]  sel_o;
    logic        conflict_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    ioexp_window_decoder dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_en_i  (win_en_i),
        .io_req_i  (io_req_i),
        .rd_i      (rd_i),
        .wr_i      (wr_i),
        .addr_i    (addr_i),
        .qual_n_o  (qual_n_o),
        .sel_o     (sel_o),
        .conflict_o(conflict_o)
    );

    // expected selects for the default four-slave build
    function automatic logic [3:0] exp_sel(input logic [15:0] a, input logic en);
        logic q_low;
        q_low = en && (a >= 16'hFC00);
        exp_sel[0] = q_low  && (a[7:0] == 8'hB2);
        exp_sel[1] = q_low  && (a[9:0] == 10'h2C4);
        exp_sel[2] = !q_low && (a == 16'h0060);
        exp_sel[3] = q_low  && (a[9:0] == 10'h0B2);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // open a cycle at a negedge; outputs are valid at the following negedge
    task automatic open_cycle(input logic [15:0] a, input logic r, input logic w);
        @(negedge clk);
        addr_i = a; rd_i = r; wr_i = w; io_req_i = 1'b1;
        @(negedge clk);
    endtask

    task automatic close_cycle();
        io_req_i = 1'b0; rd_i = 1'b0; wr_i = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R6 reset qual", 32'(qual_n_o), 32'd1);
        chk("R6 reset sel", 32'(sel_o), 32'd0);
        chk("R9 reset conflict", 32'(conflict_o), 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_sweep();
        int alias_cnt = 0;
        int low_hits = 0;
        for (int a = 0; a < 65536; a++) begin
            logic [3:0] e;
            e = exp_sel(16'(a), 1'b1);
            open_cycle(16'(a), 1'b1, 1'b0);
            chk("R1 qual", 32'(qual_n_o), 32'(!(a >= 32'hFC00)));
            chk("R2 R3 R4 sel", 32'(sel_o), 32'(e));
            chk("R9 conflict", 32'(conflict_o), 32'($countones(e) > 1));
            if (sel_o[0]) alias_cnt++;
            if (a < 32'h0400 && (sel_o[0] || sel_o[1] || sel_o[3])) low_hits++;
            close_cycle();
        end
        chk("R5 alias count", 32'(alias_cnt), 32'd4);
        chk("R5 low partial hits", 32'(low_hits), 32'd0);
    endtask

    task automatic t_strobes();
        open_cycle(16'hFDB2, 1'b0, 1'b0);
        chk("R6 no strobe qual", 32'(qual_n_o), 32'd0);
        chk("R6 no strobe sel", 32'(sel_o), 32'd0);
        wr_i = 1'b1;
        #1;
        chk("R6 write sel", 32'(sel_o), 32'b0001);
        close_cycle();
        #1;
        chk("R6 released sel", 32'(sel_o), 32'd0);
        @(negedge clk);
        chk("R6 released qual", 32'(qual_n_o), 32'd1);
    endtask

    task automatic t_hold();
        open_cycle(16'hFCB2, 1'b1, 1'b0);
        chk("R9 overlap sel", 32'(sel_o), 32'b1001);
        chk("R9 overlap flag", 32'(conflict_o), 32'd1);
        addr_i = 16'h00B2; win_en_i = 1'b0;
        @(negedge clk);
        chk("R7 held qual", 32'(qual_n_o), 32'd0);
        chk("R7 held sel", 32'(sel_o), 32'b1001);
        close_cycle();
        win_en_i = 1'b1;
        open_cycle(16'h0060, 1'b1, 1'b0);
        addr_i = 16'hFEC4;
        @(negedge clk);
        chk("R7 held high qual", 32'(qual_n_o), 32'd1);
        chk("R7 held full sel", 32'(sel_o), 32'b0100);
        close_cycle();
    endtask

    task automatic t_legacy();
        win_en_i = 1'b0;
        open_cycle(16'hFCB2, 1'b1, 1'b0);
        chk("R8 qual high", 32'(qual_n_o), 32'd1);
        chk("R8 partial off", 32'(sel_o), 32'd0);
        close_cycle();
        open_cycle(16'hFEC4, 1'b0, 1'b1);
        chk("R8 a10 off", 32'(sel_o), 32'd0);
        close_cycle();
        open_cycle(16'h0060, 1'b1, 1'b0);
        chk("R8 full on", 32'(sel_o), 32'b0100);
        close_cycle();
        open_cycle(16'hFC60, 1'b1, 1'b0);
        chk("R4 full exact", 32'(sel_o), 32'd0);
        close_cycle();
        win_en_i = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_sweep();
        t_strobes();
        t_hold();
        t_legacy();
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule